// File: doc/BRIEF.md
# Interrupt Event Counter with ASCII Line Reporter

This block watches two interrupt request lines belonging to one processor channel, one for non-critical and one for critical events. It keeps a separate event count for each kind and reports every event as a short, human-readable text line. Each line carries the channel digit, the event kind and the updated count as four hexadecimal digits. Bytes leave through a ready/valid byte port that is meant to feed a UART transmitter.

Straight after reset the block sends a one-line banner that names the channel. Only then does it send event reports. The interrupt lines are asynchronous. They pass through a synchronizer and a rising-edge detector, so a level that stays high counts as one event. An event that arrives while a line is still being sent is remembered in a one-deep pending flag for its kind. It is reported as soon as the current line is finished.

Top module: `irq_ascii_reporter`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `tx_valid_o` is low. The first line sent after reset is the 13-byte banner: 0x0A, 0x0D, "IRQ MON ", the channel digit, 0x0D, 0x0A. It always comes before any event report.
- R2: The channel digit is ASCII "0" when `proc_id_i` is 0 and ASCII "1" when it is 1. It appears in the banner and as the first byte of every report.
- R3: An event report has 10 bytes, in this order:
  - the channel digit;
  - a space;
  - the type digit, "0" for non-critical or "1" for critical;
  - a space;
  - four count digits, most significant first;
  - 0x0A, then 0x0D.
- R4: Each interrupt kind has its own counter. Both counters are zero after reset. Each rising edge on a kind's line adds one to that kind's counter only. The report carries the counter value after the increment.
- R5: The count digits are hexadecimal with leading zeros. The values 10 to 15 are written as uppercase "A" to "F".
- R6: A counter is CNT_WIDTH bits wide (16 by default). It wraps from its all-ones value to zero, so the next report after the all-ones value reads "0000".
- R7: An interrupt line held high for many cycles counts as one event and produces exactly one report.
- R8: An event that arrives while a line is being sent is reported after that line ends. When both kinds are pending at the same time, the critical report is sent first.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` does not change. The port moves to the next byte only after a cycle in which both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_noncrit_i | input | 1 | Non-critical interrupt request, asynchronous level |
| irq_crit_i | input | 1 | Critical interrupt request, asynchronous level |
| proc_id_i | input | 1 | Static channel number strap (0 or 1) |
| tx_data_o | output | 8 | Byte offered to the transmitter |
| tx_valid_o | output | 1 | tx_data_o holds a valid byte |
| tx_ready_i | input | 1 | Transmitter accepts the byte in this cycle |

## Verification
The bench builds the block with CNT_WIDTH set to 8 and SYNC_STAGES left at 2. With an 8-bit counter, a sweep of 300 critical events walks every count value, including every digit from A to F. The same sweep crosses the wrap from 00FF to 0000 and continues past it, all within a short run. The bench also covers:
- back-pressure on the byte port;
- an event that arrives during a stalled line;
- simultaneous events on both lines;
- a line held high for many cycles;
- resets with both strap values.

// File: rtl/irq_rpt_pkg.sv
package irq_rpt_pkg;

  localparam int NUM_KINDS  = 2;
  localparam int KIND_NC    = 0;
  localparam int KIND_CRIT  = 1;
  localparam int HEX_DIGITS = 4;

  localparam int BANNER_LEN = 13;
  localparam int REPORT_LEN = HEX_DIGITS + 6;
  localparam int LINE_MAX   = (BANNER_LEN > REPORT_LEN) ? BANNER_LEN : REPORT_LEN;
  localparam int IDX_W      = $clog2(LINE_MAX);

  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_ZERO  = 8'h30;

  typedef enum logic {
    LINE_REPORT = 1'b0,
    LINE_BANNER = 1'b1
  } line_kind_e;

  // One nibble to an ASCII hex digit, uppercase.
  function automatic logic [7:0] hex_char(input logic [3:0] n);
    if (n < 4'd10) hex_char = CH_ZERO + {4'd0, n};
    else           hex_char = 8'h41 + {4'd0, n} - 8'd10;
  endfunction

  // Fixed banner text; position 10 is replaced by the channel digit.
  function automatic logic [7:0] banner_char(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:    banner_char = CH_LF;
      4'd1:    banner_char = CH_CR;
      4'd2:    banner_char = "I";
      4'd3:    banner_char = "R";
      4'd4:    banner_char = "Q";
      4'd5:    banner_char = CH_SPACE;
      4'd6:    banner_char = "M";
      4'd7:    banner_char = "O";
      4'd8:    banner_char = "N";
      4'd9:    banner_char = CH_SPACE;
      4'd11:   banner_char = CH_CR;
      4'd12:   banner_char = CH_LF;
      default: banner_char = CH_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], level_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/irq_type_counters.sv
module irq_type_counters #(
  parameter int N_TYPES   = 2,
  parameter int CNT_WIDTH = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [N_TYPES-1:0]                rise_i,
  input  logic [N_TYPES-1:0]                grant_i,
  output logic [N_TYPES-1:0][CNT_WIDTH-1:0] count_o,
  output logic [N_TYPES-1:0]                pending_o
);

  for (genvar g = 0; g < N_TYPES; g++) begin : g_kind
    logic [CNT_WIDTH-1:0] cnt_q;
    logic                 pend_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        if (rise_i[g]) cnt_q <= cnt_q + 1'b1;
        pend_q <= (pend_q & ~grant_i[g]) | rise_i[g];
      end
    end

    assign count_o[g]   = cnt_q;
    assign pending_o[g] = pend_q;
  end

endmodule

// File: rtl/irq_line_fmt.sv
module irq_line_fmt
  import irq_rpt_pkg::*;
#(
  parameter int CNT_WIDTH = 16,
  parameter int TYPE_W    = 1
) (
  input  line_kind_e           kind_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 proc_id_i,
  input  logic [TYPE_W-1:0]    type_i,
  input  logic [CNT_WIDTH-1:0] cnt_i,
  output logic [7:0]           byte_o,
  output logic                 last_o
);

  localparam int PAD_W   = 4 * HEX_DIGITS;
  localparam int HEX_LO  = 4;
  localparam int HEX_HI  = HEX_LO + HEX_DIGITS - 1;

  logic [PAD_W-1:0] padded;
  logic [7:0]       id_char;
  logic [7:0]       type_char;
  int               digit;

  always_comb begin
    padded = '0;
    padded[CNT_WIDTH-1:0] = cnt_i;
  end

  assign id_char   = CH_ZERO + {7'd0, proc_id_i};
  assign type_char = CH_ZERO + 8'(type_i);

  always_comb begin
    byte_o = CH_ZERO;
    last_o = 1'b0;
    digit  = 0;
    if (kind_i == LINE_BANNER) begin
      byte_o = (int'(idx_i) == 10) ? id_char : banner_char(idx_i);
      last_o = (int'(idx_i) == BANNER_LEN - 1);
    end else begin
      if (int'(idx_i) == 0)                 byte_o = id_char;
      else if (int'(idx_i) == 2)            byte_o = type_char;
      else if (int'(idx_i) == 1 || int'(idx_i) == 3) byte_o = CH_SPACE;
      else if (int'(idx_i) <= HEX_HI) begin
        digit  = HEX_DIGITS - 1 - (int'(idx_i) - HEX_LO);
        byte_o = hex_char(padded[4*digit +: 4]);
      end else if (int'(idx_i) == HEX_HI + 1) byte_o = CH_LF;
      else begin
        byte_o = CH_CR;
        last_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_ascii_reporter.sv
module irq_ascii_reporter
  import irq_rpt_pkg::*;
#(
  parameter int CNT_WIDTH   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_noncrit_i,
  input  logic       irq_crit_i,
  input  logic       proc_id_i,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i
);

  localparam int TYPE_W = (NUM_KINDS > 1) ? $clog2(NUM_KINDS) : 1;

  logic [NUM_KINDS-1:0]                irq_vec;
  logic [NUM_KINDS-1:0]                rise;
  logic [NUM_KINDS-1:0]                pending;
  logic [NUM_KINDS-1:0]                grant;
  logic [NUM_KINDS-1:0][CNT_WIDTH-1:0] count;

  assign irq_vec[KIND_NC]   = irq_noncrit_i;
  assign irq_vec[KIND_CRIT] = irq_crit_i;

  for (genvar g = 0; g < NUM_KINDS; g++) begin : g_sync
    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .level_i (irq_vec[g]),
      .rise_o  (rise[g])
    );
  end

  irq_type_counters #(.N_TYPES(NUM_KINDS), .CNT_WIDTH(CNT_WIDTH)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (rise),
    .grant_i   (grant),
    .count_o   (count),
    .pending_o (pending)
  );

  // Line sequencer state
  logic                 busy_q;
  logic                 banner_req_q;
  line_kind_e           kind_q;
  logic [IDX_W-1:0]     idx_q;
  logic [TYPE_W-1:0]    snap_type_q;
  logic [CNT_WIDTH-1:0] snap_cnt_q;
  logic [TYPE_W-1:0]    grant_idx;
  logic                 start_report;
  logic [7:0]           fmt_byte;
  logic                 fmt_last;
  logic                 out_load;

  // Highest kind index wins: critical before non-critical.
  always_comb begin
    grant_idx = '0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      if (pending[k]) grant_idx = TYPE_W'(k);
    end
  end

  assign start_report = !busy_q && !banner_req_q && (|pending);

  always_comb begin
    grant = '0;
    if (start_report) grant[grant_idx] = 1'b1;
  end

  irq_line_fmt #(.CNT_WIDTH(CNT_WIDTH), .TYPE_W(TYPE_W)) u_fmt (
    .kind_i    (kind_q),
    .idx_i     (idx_q),
    .proc_id_i (proc_id_i),
    .type_i    (snap_type_q),
    .cnt_i     (snap_cnt_q),
    .byte_o    (fmt_byte),
    .last_o    (fmt_last)
  );

  assign out_load = !tx_valid_o || tx_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      banner_req_q <= 1'b1;
      kind_q       <= LINE_BANNER;
      idx_q        <= '0;
      snap_type_q  <= '0;
      snap_cnt_q   <= '0;
      tx_valid_o   <= 1'b0;
      tx_data_o    <= '0;
    end else begin
      if (!busy_q) begin
        if (banner_req_q) begin
          busy_q       <= 1'b1;
          kind_q       <= LINE_BANNER;
          idx_q        <= '0;
          banner_req_q <= 1'b0;
        end else if (start_report) begin
          busy_q      <= 1'b1;
          kind_q      <= LINE_REPORT;
          idx_q       <= '0;
          snap_type_q <= grant_idx;
          snap_cnt_q  <= count[grant_idx];
        end
      end
      if (out_load) begin
        if (busy_q) begin
          tx_valid_o <= 1'b1;
          tx_data_o  <= fmt_byte;
          if (fmt_last) busy_q <= 1'b0;
          else          idx_q  <= idx_q + 1'b1;
        end else begin
          tx_valid_o <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/irq_ascii_reporter_chk.sv
module irq_ascii_reporter_chk #(
  parameter int CNT_WIDTH = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic [7:0]           tx_data,
  input logic [CNT_WIDTH-1:0] cnt_nc,
  input logic [CNT_WIDTH-1:0] cnt_cr,
  input logic [1:0]           pend,
  input logic [1:0]           grant
);

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !tx_valid);

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R4
  nc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_nc != $past(cnt_nc)) |-> (cnt_nc == CNT_WIDTH'($past(cnt_nc) + 1'b1)));

  // R4
  cr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_cr != $past(cnt_cr)) |-> (cnt_cr == CNT_WIDTH'($past(cnt_cr) + 1'b1)));

  // R8
  pend_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (pend[0] && !grant[0]) |=> pend[0]);

  // R8
  crit_first_chk: assert property (@(posedge clk) disable iff (rst)
    (pend[1] && pend[0]) |-> !grant[0]);

endmodule

bind irq_ascii_reporter irq_ascii_reporter_chk #(.CNT_WIDTH(CNT_WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_valid (tx_valid_o),
  .tx_ready (tx_ready_i),
  .tx_data  (tx_data_o),
  .cnt_nc   (count[0]),
  .cnt_cr   (count[1]),
  .pend     (pending),
  .grant    (grant)
);

// File: tb/irq_ascii_reporter_test.sv
`timescale 1ns/1ps
module irq_ascii_reporter_test;

  localparam int CW = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       irq_nc = 1'b0;
  logic       irq_cr = 1'b0;
  logic       pid = 1'b0;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready = 1'b1;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] rxq[$];

  always #2.5 clk = ~clk;

  irq_ascii_reporter #(.CNT_WIDTH(CW), .SYNC_STAGES(2)) uut (
    .clk           (clk),
    .rst           (rst),
    .irq_noncrit_i (irq_nc),
    .irq_crit_i    (irq_cr),
    .proc_id_i     (pid),
    .tx_data_o     (tx_data),
    .tx_valid_o    (tx_valid),
    .tx_ready_i    (tx_ready)
  );

  // Bytes accepted at the next rising edge are captured half a cycle early.
  always @(negedge clk) begin
    if (!rst && tx_valid && tx_ready) rxq.push_back(tx_data);
  end

  function automatic logic [7:0] hexc(input int n);
    return (n < 10) ? 8'(48 + n) : 8'(65 + n - 10);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_line(input logic [7:0] exp[], input string req, input string what);
    int waited = 0;
    bit ok = 1'b1;
    int bad_i = 0;
    logic [7:0] got [];
    while (rxq.size() < exp.size() && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    if (rxq.size() < exp.size()) begin
      check(1'b0, req, {what, " missing bytes"}, rxq.size(), exp.size());
      return;
    end
    got = new[exp.size()];
    foreach (exp[i]) got[i] = rxq.pop_front();
    foreach (exp[i]) if (ok && got[i] !== exp[i]) begin ok = 1'b0; bad_i = i; end
    check(ok, req, $sformatf("%s byte %0d", what, bad_i), int'(got[bad_i]), int'(exp[bad_i]));
  endtask

  task automatic expect_banner(input int p);
    logic [7:0] e [] = '{8'h0A, 8'h0D, "I", "R", "Q", " ", "M", "O", "N", " ",
                         8'(48 + p), 8'h0D, 8'h0A};
    compare_line(e, "R1 R2", "banner");
  endtask

  task automatic expect_report(input int p, input int t, input int c, input string req);
    logic [7:0] e [] = new[10];
    e[0] = 8'(48 + p); e[1] = " "; e[2] = 8'(48 + t); e[3] = " ";
    for (int k = 0; k < 4; k++) e[4 + k] = hexc((c >> (4 * (3 - k))) & 15);
    e[8] = 8'h0A; e[9] = 8'h0D;
    compare_line(e, req, $sformatf("report p%0d t%0d c%0h", p, t, c));
  endtask

  task automatic pulse(input bit nc, input bit cr);
    @(posedge clk); #1;
    irq_nc = nc; irq_cr = cr;
    repeat (3) @(posedge clk);
    #1;
    irq_nc = 1'b0; irq_cr = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic do_reset(input logic p);
    @(posedge clk); #1;
    rst = 1'b1; pid = p; irq_nc = 1'b0; irq_cr = 1'b0; tx_ready = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(tx_valid == 1'b0, "R1", "valid during reset", tx_valid, 0);
    rxq.delete();
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(tx_valid == 1'b0, "R1", "valid first cycle after reset", tx_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    int waited;

    // Channel 0: event right after reset still follows the banner (R1)
    do_reset(1'b0);
    pulse(1'b1, 1'b0);
    expect_banner(0);
    expect_report(0, 0, 1, "R3 R4");

    // Sweep critical counts across all digits and past the wrap (R5, R6)
    for (int i = 1; i <= 300; i++) begin
      pulse(1'b0, 1'b1);
      expect_report(0, 1, i % (1 << CW), (i % (1 << CW) == 0) ? "R6" : "R5 R4");
    end

    // Non-critical counter untouched by critical traffic (R4)
    pulse(1'b1, 1'b0);
    expect_report(0, 0, 2, "R4");

    // Held level counts once (R7)
    @(posedge clk); #1;
    irq_nc = 1'b1;
    repeat (60) @(posedge clk);
    #1;
    irq_nc = 1'b0;
    expect_report(0, 0, 3, "R7");
    repeat (40) @(negedge clk);
    check(rxq.size() == 0, "R7", "extra bytes after held level", rxq.size(), 0);
    pulse(1'b1, 1'b0);
    expect_report(0, 0, 4, "R7");

    // Stall: data held, event during stall reported afterwards (R9, R8)
    @(posedge clk); #1;
    tx_ready = 1'b0;
    pulse(1'b1, 1'b0);
    waited = 0;
    while (!tx_valid && waited < 100) begin @(negedge clk); waited++; end
    held = tx_data;
    check(tx_valid && held == "0", "R9", "first stalled byte", held, 8'h30);
    pulse(1'b0, 1'b1);
    repeat (5) @(negedge clk);
    check(tx_valid && tx_data == held, "R9", "byte held while not ready", tx_data, held);
    @(posedge clk); #1;
    tx_ready = 1'b1;
    expect_report(0, 0, 5, "R8 R9");
    expect_report(0, 1, 301 % (1 << CW), "R8");

    // Simultaneous events: critical first (R8)
    pulse(1'b1, 1'b1);
    expect_report(0, 1, 302 % (1 << CW), "R8");
    expect_report(0, 0, 6, "R8");

    // Channel 1: digit from strap, counters cleared (R2, R4)
    do_reset(1'b1);
    expect_banner(1);
    pulse(1'b0, 1'b1);
    expect_report(1, 1, 1, "R2 R4");
    pulse(1'b1, 1'b0);
    expect_report(1, 0, 1, "R2 R3");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule